// File: doc/BRIEF.md
# Parallel Capture Port with Word Packer

This block takes samples from an external parallel bus up to 20 lines wide and assembles them into 32-bit words. The external capture clock is not used as a clock. It is sampled in the system clock domain and turned into a capture strobe. The block watches the selected transition of that line, rising or falling, and takes a sample on each such transition during which the active-low hold line is low. A transition seen while hold is high leaves the block unchanged.

A 2-bit mode chooses how samples are packed. The choices are four 8-bit samples, two 16-bit samples, a 10/11/11-bit triple, or one 20-bit sample that is placed left-justified. Samples fill the word from its least significant field upward. A finished word is pushed into a six-entry receive FIFO. A consumer empties the FIFO through a ready/valid handshake. The FIFO level and a sticky overflow flag are driven as outputs.

Top module: `pcap_port`

## Requirements
- R1: With mode 2'b00, four captures make one word. Sample k contributes data lines 7:0 at word bits 8k+7:8k, with k = 0 for the first capture. Data lines 19:8 are ignored.
- R2: With mode 2'b01, two captures make one word. The first capture's lines 15:0 go to word bits 15:0 and the second capture's to bits 31:16. Lines 19:16 are ignored.
- R3: With mode 2'b10, three captures make one word. Lines 9:0 of the first capture go to bits 9:0. Lines 10:0 of the second go to bits 20:10, and lines 10:0 of the third go to bits 31:21.
- R4: With mode 2'b11, every capture makes one word. The word holds lines 19:0 in bits 31:12, and bits 11:0 are zero.
- R5: A selected capture-clock transition during which hold_ni is high captures nothing.
- R6: With edge_fall_i = 0, captures happen on low-to-high transitions of cap_clk_i. With edge_fall_i = 1, they happen on high-to-low transitions. The other transition never captures.
- R7: The FIFO holds up to 6 words and hands them out in the order they were completed. level_o gives the number of stored words.
- R8: A word completed while the FIFO is full, with no pop in the same cycle, is dropped. The stored words are unchanged, and overflow_o becomes 1 and stays 1 until a port clear.
- R9: A cycle with port_clr_i high empties the FIFO, clears overflow_o and throws away any partly packed word.
- R10: A change of mode_i throws away any partly packed word. Packing then restarts at the lowest field.
- R11: While en_i is low, no capture happens and the stored words are kept.
- R12: While out_valid_o is high and out_ready_i is low, out_data_o and out_valid_o hold their values. A cycle with both high removes exactly one word.
- R13: During reset, level_o is 0, out_valid_o is 0 and overflow_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable; captures only while high |
| port_clr_i | input | 1 | Synchronous port clear (FIFO, overflow, packer) |
| mode_i | input | 2 | Packing mode: 00 4x8, 01 2x16, 10 10/11/11, 11 20-bit |
| edge_fall_i | input | 1 | 0: rising capture edge, 1: falling capture edge |
| cap_clk_i | input | 1 | External capture clock, sampled by clk_i |
| hold_ni | input | 1 | Active-low qualifier for each capture edge |
| data_i | input | 20 | External sample bus |
| out_data_o | output | 32 | Head-of-FIFO packed word |
| out_valid_o | output | 1 | FIFO not empty |
| out_ready_i | input | 1 | Consumer accepts the head word |
| level_o | output | 3 | Number of stored words |
| overflow_o | output | 1 | Sticky flag for a dropped word |

## Verification
The assertions assume that cap_clk_i, hold_ni and data_i are stable for whole system-clock cycles. They also assume each capture-clock level lasts at least one cycle, so that an edge is seen as one change between two samples. The stimulus meets this by changing every input only at the falling system edge. Each capture-clock phase is held for a full cycle, and hold_ni is kept high whenever the bench moves the capture clock to its idle level or changes edge polarity or mode. With this, only the edges the bench intends can capture.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned BUS_W  = 20;

    typedef enum logic [1:0] {
        PACK_4X8   = 2'b00,
        PACK_2X16  = 2'b01,
        PACK_TRIO  = 2'b10,
        PACK_20L   = 2'b11
    } pack_mode_e;

    // Index of the last sample of a word for each mode
    function automatic logic [1:0] last_slot(input pack_mode_e m);
        case (m)
            PACK_4X8:  return 2'd3;
            PACK_2X16: return 2'd1;
            PACK_TRIO: return 2'd2;
            default:   return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/pcap_edge.sv
module pcap_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cap_clk_i,
    input  logic fall_sel_i,
    output logic edge_o
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = cap_clk_i;
        if (fall_sel_i) begin
            edge_o = st_q.prev & ~cap_clk_i;
        end else begin
            edge_o = ~st_q.prev & cap_clk_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pcap_packer.sv
module pcap_packer
    import pcap_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  pack_mode_e        mode_i,
    input  logic              take_i,
    input  logic [BUS_W-1:0]  sample_i,
    output logic [WORD_W-1:0] word_o,
    output logic              done_o
);
    typedef struct packed {
        pack_mode_e         mode;
        logic [1:0]         slot;
        logic [WORD_W-1:0]  acc;
    } pack_st_t;

    pack_st_t st_d, st_q;

    logic              restart;
    logic [1:0]        base_slot;
    logic [WORD_W-1:0] base_acc;
    logic [WORD_W-1:0] placed;
    logic              is_last;

    always_comb begin
        restart   = (mode_i != st_q.mode);
        base_slot = restart ? 2'd0 : st_q.slot;
        base_acc  = restart ? '0 : st_q.acc;
        is_last   = (base_slot == last_slot(mode_i));

        case (mode_i)
            PACK_4X8:  placed = {24'b0, sample_i[7:0]} << {base_slot, 3'b000};
            PACK_2X16: placed = {16'b0, sample_i[15:0]} << {base_slot, 4'b0000};
            PACK_TRIO: begin
                case (base_slot)
                    2'd0:    placed = {22'b0, sample_i[9:0]};
                    2'd1:    placed = {11'b0, sample_i[10:0], 10'b0};
                    default: placed = {sample_i[10:0], 21'b0};
                endcase
            end
            default:   placed = {sample_i[19:0], 12'b0};
        endcase

        st_d      = st_q;
        st_d.mode = mode_i;
        st_d.slot = base_slot;
        st_d.acc  = base_acc;
        done_o    = 1'b0;
        word_o    = base_acc | placed;

        if (clr_i) begin
            st_d.slot = 2'd0;
            st_d.acc  = '0;
        end else if (take_i) begin
            if (is_last) begin
                done_o    = 1'b1;
                st_d.slot = 2'd0;
                st_d.acc  = '0;
            end else begin
                st_d.slot = base_slot + 2'd1;
                st_d.acc  = base_acc | placed;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pcap_fifo.sv
module pcap_fifo #(
    parameter int unsigned DEPTH = 6,
    parameter int unsigned W     = 32,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             push_i,
    input  logic [W-1:0]     wdata_i,
    input  logic             ready_i,
    output logic [W-1:0]     rdata_o,
    output logic             valid_o,
    output logic [LVL_W-1:0] level_o,
    output logic             ovf_o
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [LVL_W-1:0]        lvl;
        logic                    ovf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     pop;
    logic     accept;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        valid_o = (st_q.lvl != '0);
        rdata_o = st_q.mem[st_q.rd];
        level_o = st_q.lvl;
        ovf_o   = st_q.ovf;
        pop     = valid_o & ready_i;
        accept  = push_i & ((st_q.lvl != FULL_LVL) | pop);

        st_d = st_q;
        if (clr_i) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.lvl = '0;
            st_d.ovf = 1'b0;
        end else begin
            if (pop) begin
                st_d.rd = bump(st_q.rd);
            end
            if (accept) begin
                st_d.mem[st_q.wr] = wdata_i;
                st_d.wr           = bump(st_q.wr);
            end
            if (push_i && !accept) begin
                st_d.ovf = 1'b1;
            end
            st_d.lvl = st_q.lvl + LVL_W'(accept) - LVL_W'(pop);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pcap_port.sv
module pcap_port
    import pcap_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 6,
    localparam int unsigned LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              port_clr_i,
    input  logic [1:0]        mode_i,
    input  logic              edge_fall_i,
    input  logic              cap_clk_i,
    input  logic              hold_ni,
    input  logic [BUS_W-1:0]  data_i,
    output logic [WORD_W-1:0] out_data_o,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [LVL_W-1:0]  level_o,
    output logic              overflow_o
);
    logic              cap_edge;
    logic              take;
    logic [WORD_W-1:0] packed_word;
    logic              word_done;

    pcap_edge edge_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cap_clk_i  (cap_clk_i),
        .fall_sel_i (edge_fall_i),
        .edge_o     (cap_edge)
    );

    assign take = cap_edge & en_i & ~hold_ni & ~port_clr_i;

    pcap_packer packer_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (port_clr_i),
        .mode_i   (pack_mode_e'(mode_i)),
        .take_i   (take),
        .sample_i (data_i),
        .word_o   (packed_word),
        .done_o   (word_done)
    );

    pcap_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (WORD_W)
    ) fifo_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (port_clr_i),
        .push_i  (word_done),
        .wdata_i (packed_word),
        .ready_i (out_ready_i),
        .rdata_o (out_data_o),
        .valid_o (out_valid_o),
        .level_o (level_o),
        .ovf_o   (overflow_o)
    );
endmodule

// File: rtl/pcap_port_chk.sv
module pcap_port_chk #(
    parameter int unsigned DEPTH = 6,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              en_i,
    input logic              port_clr_i,
    input logic              hold_ni,
    input logic [31:0]       out_data_o,
    input logic              out_valid_o,
    input logic              out_ready_i,
    input logic [LVL_W-1:0]  level_o,
    input logic              overflow_o
);
    logic popping;
    assign popping = out_valid_o & out_ready_i;

    assert_reset_state_R13: assert property (@(posedge clk_i)
        !rst_ni |=> (level_o == '0 && !out_valid_o && !overflow_o));

    assert_level_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        level_o <= LVL_W'(DEPTH));

    assert_overflow_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (overflow_o && !port_clr_i) |=> overflow_o);

    assert_no_capture_on_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_ni && !port_clr_i && !popping) |=> (level_o == $past(level_o)));

    assert_disabled_keeps_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !port_clr_i && !popping) |=> (level_o == $past(level_o)));

    assert_stall_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_ready_i && !port_clr_i) |=> (out_valid_o && $stable(out_data_o)));

    assert_clear_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        port_clr_i |=> (level_o == '0 && !overflow_o));
endmodule

bind pcap_port pcap_port_chk #(.DEPTH(FIFO_DEPTH)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .port_clr_i  (port_clr_i),
    .hold_ni     (hold_ni),
    .out_data_o  (out_data_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .level_o     (level_o),
    .overflow_o  (overflow_o)
);

// File: tb/pcap_port_tb.sv
module pcap_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        en_i = 1'b1;
    logic        port_clr_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic        edge_fall_i = 1'b0;
    logic        cap_clk_i = 1'b0;
    logic        hold_ni = 1'b1;
    logic [19:0] data_i = '0;
    logic [31:0] out_data_o;
    logic        out_valid_o;
    logic        out_ready_i = 1'b0;
    logic [2:0]  level_o;
    logic        overflow_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pcap_port dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .en_i        (en_i),
        .port_clr_i  (port_clr_i),
        .mode_i      (mode_i),
        .edge_fall_i (edge_fall_i),
        .cap_clk_i   (cap_clk_i),
        .hold_ni     (hold_ni),
        .data_i      (data_i),
        .out_data_o  (out_data_o),
        .out_valid_o (out_valid_o),
        .out_ready_i (out_ready_i),
        .level_o     (level_o),
        .overflow_o  (overflow_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One selected capture-clock edge with sample d; idle phase has hold high.
    task automatic drive_sample(input logic [19:0] d, input logic hold);
        @(negedge clk);
        cap_clk_i = edge_fall_i;
        hold_ni   = 1'b1;
        @(negedge clk);
        cap_clk_i = ~edge_fall_i;
        data_i    = d;
        hold_ni   = hold;
        @(negedge clk);
        hold_ni   = 1'b1;
    endtask

    task automatic pop_expect(input logic [31:0] exp, input string tag);
        chk({tag, " valid"}, {31'b0, out_valid_o}, 32'd1);
        chk({tag, " data"}, out_data_o, exp);
        out_ready_i = 1'b1;
        @(negedge clk);
        out_ready_i = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode_i = m;
        @(negedge clk);
    endtask

    // Expected field contribution, computed from the field table in the requirements.
    function automatic logic [31:0] field_of(input int m, input int k, input logic [19:0] s);
        case (m)
            0: return 32'(s % 256) * (32'd1 << (8 * k));
            1: return 32'(s % 65536) * (32'd1 << (16 * k));
            2: begin
                if (k == 0) return 32'(s % 1024);
                if (k == 1) return 32'(s % 2048) * 32'd1024;
                return 32'(s % 2048) * 32'h0020_0000;
            end
            default: return 32'(s) * 32'd4096;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        string tags[4] = '{"R1", "R2", "R3", "R4"};
        int nsamp[4] = '{4, 2, 3, 1};
        logic [31:0] expw[3];
        logic [31:0] held;
        logic [2:0] lvl0;

        repeat (3) @(negedge clk);
        chk("R13 level", {29'b0, level_o}, 32'd0);
        chk("R13 valid", {31'b0, out_valid_o}, 32'd0);
        chk("R13 overflow", {31'b0, overflow_o}, 32'd0);
        rst_ni = 1'b1;
        @(negedge clk);

        // Sweep every mode under both capture edges (R1..R4, R6, R7)
        for (int fall = 0; fall < 2; fall++) begin
            for (int m = 0; m < 4; m++) begin
                @(negedge clk);
                edge_fall_i = fall[0];
                mode_i = m[1:0];
                @(negedge clk);
                for (int w = 0; w < 3; w++) begin
                    expw[w] = '0;
                    for (int s = 0; s < nsamp[m]; s++) begin
                        logic [19:0] raw;
                        raw = 20'((w * 4099 + s * 977 + m * 131 + fall * 7 + 1) * 255);
                        expw[w] = expw[w] + field_of(m, s, raw);
                        drive_sample(raw, 1'b0);
                    end
                    chk({"R7 level ", tags[m]}, {29'b0, level_o}, 32'(w + 1));
                end
                for (int w = 0; w < 3; w++) begin
                    pop_expect(expw[w], fall ? {tags[m], " R6 fall"} : tags[m]);
                end
            end
        end

        // R5: hold high blocks a capture
        set_mode(2'b11);
        edge_fall_i = 1'b0;
        drive_sample(20'h12345, 1'b1);
        chk("R5 level", {29'b0, level_o}, 32'd0);
        drive_sample(20'h54321, 1'b0);
        chk("R5 level after qualified edge", {29'b0, level_o}, 32'd1);
        pop_expect(32'h5432_1000, "R5");

        // R6: in falling mode a rising edge does not capture
        @(negedge clk);
        edge_fall_i = 1'b1;
        cap_clk_i = 1'b0;
        @(negedge clk);
        hold_ni = 1'b0;
        cap_clk_i = 1'b1;
        data_i = 20'hAAAAA;
        @(negedge clk);
        chk("R6 rising ignored", {29'b0, level_o}, 32'd0);
        cap_clk_i = 1'b0;
        data_i = 20'h0BEEF;
        @(negedge clk);
        hold_ni = 1'b1;
        chk("R6 falling captured", {29'b0, level_o}, 32'd1);
        pop_expect(32'h0BEE_F000, "R6");
        @(negedge clk);
        edge_fall_i = 1'b0;
        @(negedge clk);

        // R7/R8: fill past capacity
        for (int i = 0; i < 8; i++) drive_sample(20'(i + 16), 1'b0);
        chk("R7 full level", {29'b0, level_o}, 32'd6);
        chk("R8 overflow set", {31'b0, overflow_o}, 32'd1);
        for (int i = 0; i < 6; i++) pop_expect(32'(i + 16) << 12, "R8 kept order");
        chk("R8 overflow sticky", {31'b0, overflow_o}, 32'd1);
        chk("R7 empty", {29'b0, level_o}, 32'd0);

        // R9: port clear flushes FIFO, overflow and a partial word
        drive_sample(20'h00077, 1'b0);
        set_mode(2'b01);
        drive_sample(20'h01111, 1'b0);
        @(negedge clk);
        port_clr_i = 1'b1;
        @(negedge clk);
        port_clr_i = 1'b0;
        chk("R9 level", {29'b0, level_o}, 32'd0);
        chk("R9 overflow", {31'b0, overflow_o}, 32'd0);
        drive_sample(20'hF2222, 1'b0);
        drive_sample(20'h03333, 1'b0);
        chk("R9 one word", {29'b0, level_o}, 32'd1);
        pop_expect(32'h3333_2222, "R9 partial dropped");

        // R10: mode change drops a partial word
        set_mode(2'b00);
        drive_sample(20'h000AA, 1'b0);
        drive_sample(20'h000BB, 1'b0);
        set_mode(2'b01);
        drive_sample(20'h0C0C0, 1'b0);
        drive_sample(20'h0D0D0, 1'b0);
        chk("R10 level", {29'b0, level_o}, 32'd1);
        pop_expect(32'hD0D0_C0C0, "R10");

        // R11: disabled port captures nothing, keeps contents
        set_mode(2'b11);
        drive_sample(20'h0ABCD, 1'b0);
        @(negedge clk);
        en_i = 1'b0;
        for (int i = 0; i < 3; i++) drive_sample(20'(i * 3 + 5), 1'b0);
        chk("R11 level", {29'b0, level_o}, 32'd1);
        pop_expect(32'h0ABC_D000, "R11 kept");
        chk("R11 empty", {29'b0, level_o}, 32'd0);
        @(negedge clk);
        en_i = 1'b1;

        // R12: stalled head stays stable while more words arrive
        drive_sample(20'h11111, 1'b0);
        held = out_data_o;
        lvl0 = level_o;
        drive_sample(20'h22222, 1'b0);
        drive_sample(20'h33333, 1'b0);
        chk("R12 stable data", out_data_o, held);
        chk("R12 stable data value", held, 32'h1111_1000);
        chk("R12 level grew", {29'b0, level_o}, 32'(lvl0) + 32'd2);
        pop_expect(32'h1111_1000, "R12");
        chk("R12 one removed", {29'b0, level_o}, 32'd2);
        pop_expect(32'h2222_2000, "R12");
        pop_expect(32'h3333_3000, "R12");
        chk("R12 drained", {31'b0, out_valid_o}, 32'd0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule